// File: doc/BRIEF.md
# DDR SDRAM Refresh and Self-Refresh Scheduler

This block sits beside the command arbiter of a DDR SDRAM controller and decides when the memory must be refreshed. A free-running interval counter adds one owed refresh every `REFI_CYC` cycles. At 6 ns per clock, the default of 1300 cycles matches a 7.8 us average interval, so 8K refresh commands cover every row in the expected period.

While refreshes are owed, the scheduler raises `refresh_req`. The arbiter grants the request with a one-cycle `refresh_ack`. The scheduler then closes any open bank with a precharge-all command (address bit 10 high), waits until every bank reports idle, and issues an auto refresh. After that it holds off all other traffic for the refresh cycle time. Up to `MAX_DEBT` refreshes may be postponed. When the debt reaches that limit, the request turns urgent, and new activates stay blocked until the debt is fully paid.

The block also runs self refresh. It drops clock enable when entry is requested while all banks are idle. During self refresh the interval counter keeps running, but no debt builds up. On exit, clock enable rises, the debt is cleared, and a single auto refresh is issued once the non-read exit wait has passed. Reads stay blocked for the longer read exit wait, which is counted in clocks.

Top module: `refresh_sched`

## Requirements
- R1: After reset, the owed-refresh count rises by exactly one on every `REFI_CYC`-th rising clock edge (edge number k with k mod `REFI_CYC` = 0, counting edges since reset release).
- R2: `refresh_req` is high exactly when the owed-refresh count is non-zero.
- R3: The owed-refresh count never exceeds `MAX_DEBT`, and `refresh_urgent` is high exactly when it equals `MAX_DEBT`.
- R4: `block_activate` rises when the count reaches `MAX_DEBT` and stays high until the count returns to zero, even after `refresh_urgent` has fallen.
- R5: A `refresh_ack` in the idle state with a non-zero count and some bank open gives a one-cycle `cmd_precharge_all` with `cmd_a10` high on the next cycle. The scheduler then waits for `banks_idle` before issuing the refresh.
- R6: A `refresh_ack` in the idle state with a non-zero count and all banks idle gives `cmd_refresh` on the next cycle. The count drops by one at the end of that cycle.
- R7: From the cycle of `cmd_refresh`, `hold_cmds` stays high for `RFC_CYC` cycles in total, so the earliest other command is `RFC_CYC` cycles after the refresh.
- R8: Self-refresh entry happens only from the idle state with `banks_idle` high, and `cke` falls on the next cycle. A request made while some bank is open is ignored and `cke` stays high.
- R9: While `cke` is low, the owed-refresh count does not change.
- R10: On `sr_exit_req`, `cke` rises on the next cycle (call it cycle E), and the count reads zero in that cycle. `cmd_refresh` is issued in cycle E+`XSNR_CYC`, and `hold_cmds` stays high until then.
- R11: `read_block` is high throughout self refresh and stays high up to and including cycle E+`XSRD_CYC`-1.
- R12: During and right after reset, `cke` is high and every other output is low, with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | High when every bank is precharged |
| refresh_ack | input | 1 | Arbiter grant of the refresh request |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh |
| refresh_req | output | 1 | Refreshes are owed |
| refresh_urgent | output | 1 | Owed count is at its limit |
| block_activate | output | 1 | Arbiter must not open new rows |
| hold_cmds | output | 1 | Arbiter must issue no command |
| cmd_precharge_all | output | 1 | Issue precharge to every bank |
| cmd_a10 | output | 1 | Value of address bit 10 with the issued command |
| cmd_refresh | output | 1 | Issue an auto refresh |
| cke | output | 1 | Clock enable to the memory |
| read_block | output | 1 | Reads not yet allowed after self refresh |
| debt_count | output | $clog2(MAX_DEBT+1) | Number of owed refreshes |

## Verification
A corrupted interval counter shows up on `debt_count` at the very next expected increment edge. That happens within one interval, and the table walk catches the error as the count running early or late. A wrong state register shows up at once as a missing or extra `cmd_precharge_all`/`cmd_refresh`, or as `hold_cmds` dropping a cycle early. A wrong exit-wait counter moves the post-exit refresh or the fall of `read_block` off its exact cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DRAIN,
    ST_REF,
    ST_RFC,
    ST_SR,
    ST_XWAIT
  } sched_state_t;

  // owed-refresh arithmetic: saturating add, floor-at-zero subtract
  function automatic logic [31:0] debt_step(input logic [31:0] d, input logic add,
                                            input logic sub, input logic [31:0] cap);
    logic [31:0] r;
    r = d;
    if (add && r < cap) r = r + 32'd1;
    if (sub && r != 32'd0) r = r - 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int REFI_CYC = 1300
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(REFI_CYC);
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assert_single_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/debt_tracker.sv
module debt_tracker
  import refsched_pkg::*;
#(
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add,
  input  logic          sub,
  input  logic          clear,
  output logic [DW-1:0] debt,
  output logic          urgent,
  output logic          block
);
  logic [DW-1:0] debt_q, debt_n;
  logic          block_q;

  always_comb begin
    if (clear) debt_n = '0;
    else       debt_n = DW'(debt_step(32'(debt_q), add, sub, 32'(MAX_DEBT)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      debt_q  <= '0;
      block_q <= 1'b0;
    end else begin
      debt_q <= debt_n;
      if (debt_n == DW'(MAX_DEBT)) block_q <= 1'b1;
      else if (debt_n == '0)       block_q <= 1'b0;
    end
  end

  assign debt   = debt_q;
  assign urgent = (debt_q == DW'(MAX_DEBT));
  assign block  = block_q;

  assert_debt_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= DW'(MAX_DEBT));
  assert_urgent_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> block);

endmodule

// File: rtl/exit_timer.sv
module exit_timer #(
  parameter int XSNR_CYC = 13,
  parameter int XSRD_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_sr,
  output logic nonread_last,
  output logic read_block
);
  localparam int XW = $clog2(XSRD_CYC + 1);
  localparam logic [XW-1:0] RD_DONE = XW'(XSRD_CYC);
  localparam logic [XW-1:0] NR_LAST = XW'(XSNR_CYC - 1);

  logic [XW-1:0] xs_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              xs_q <= RD_DONE;
    else if (in_sr)          xs_q <= '0;
    else if (xs_q < RD_DONE) xs_q <= xs_q + 1'b1;
  end

  assign nonread_last = !in_sr && (xs_q == NR_LAST);
  assign read_block   = in_sr || (xs_q < RD_DONE);

  assert_read_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |=> read_block);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int REFI_CYC = 1300,
  parameter int RFC_CYC  = 12,
  parameter int XSNR_CYC = 13,
  parameter int XSRD_CYC = 200,
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          banks_idle,
  input  logic          refresh_ack,
  input  logic          sr_enter_req,
  input  logic          sr_exit_req,
  output logic          refresh_req,
  output logic          refresh_urgent,
  output logic          block_activate,
  output logic          hold_cmds,
  output logic          cmd_precharge_all,
  output logic          cmd_a10,
  output logic          cmd_refresh,
  output logic          cke,
  output logic          read_block,
  output logic [DW-1:0] debt_count
);
  localparam int RW = $clog2(RFC_CYC);

  sched_state_t state_q, state_n;
  logic [RW-1:0] rfc_q;
  logic interval_tick, nonread_last, in_sr, sr_leave, debt_add, debt_sub;

  // named internal events
  assign in_sr    = (state_q == ST_SR);
  assign sr_leave = in_sr && sr_exit_req;
  assign debt_add = interval_tick && !in_sr && (state_q != ST_XWAIT);
  assign debt_sub = (state_q == ST_REF);

  refi_timer #(.REFI_CYC(REFI_CYC)) u_refi (
    .clk(clk), .rst_n(rst_n), .tick(interval_tick));

  debt_tracker #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst_n(rst_n), .add(debt_add), .sub(debt_sub), .clear(sr_leave),
    .debt(debt_count), .urgent(refresh_urgent), .block(block_activate));

  exit_timer #(.XSNR_CYC(XSNR_CYC), .XSRD_CYC(XSRD_CYC)) u_exit (
    .clk(clk), .rst_n(rst_n), .in_sr(in_sr),
    .nonread_last(nonread_last), .read_block(read_block));

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (refresh_ack && debt_count != '0) state_n = banks_idle ? ST_REF : ST_PRE;
        else if (sr_enter_req && banks_idle) state_n = ST_SR;
      end
      ST_PRE:   state_n = ST_DRAIN;
      ST_DRAIN: if (banks_idle) state_n = ST_REF;
      ST_REF:   state_n = ST_RFC;
      ST_RFC:   if (rfc_q == '0) state_n = ST_IDLE;
      ST_SR:    if (sr_exit_req) state_n = ST_XWAIT;
      ST_XWAIT: if (nonread_last) state_n = ST_REF;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rfc_q   <= '0;
    end else begin
      state_q <= state_n;
      if (state_q == ST_REF)      rfc_q <= RW'(RFC_CYC - 2);
      else if (state_q == ST_RFC) rfc_q <= rfc_q - 1'b1;
    end
  end

  assign refresh_req       = (debt_count != '0);
  assign hold_cmds         = (state_q != ST_IDLE);
  assign cmd_precharge_all = (state_q == ST_PRE);
  assign cmd_a10           = (state_q == ST_PRE);
  assign cmd_refresh       = (state_q == ST_REF);
  assign cke               = !in_sr;

  assert_pre_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_precharge_all |=> !cmd_precharge_all);
  assert_rfc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |=> hold_cmds);
  assert_refresh_cke_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |-> cke);
  assert_sr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (cke || $stable(debt_count)));
  assert_exit_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (debt_count == '0 && hold_cmds));

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int REFI = 40;
  localparam int RFC  = 12;
  localparam int XSNR = 13;
  localparam int XSRD = 200;
  localparam int MAXD = 8;
  localparam int NV   = 9;

  // edge count since reset release, expected debt, expected urgent
  localparam int VK [NV] = '{0, 39, 40, 79, 80, 200, 319, 320, 400};
  localparam int VD [NV] = '{0, 0, 1, 1, 2, 5, 7, 8, 8};
  localparam int VU [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1, refresh_ack = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
  logic refresh_req, refresh_urgent, block_activate, hold_cmds;
  logic cmd_precharge_all, cmd_a10, cmd_refresh, cke, read_block;
  logic [3:0] debt_count;

  int total = 0;
  int failed = 0;
  int k = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  refresh_sched #(.REFI_CYC(REFI), .RFC_CYC(RFC), .XSNR_CYC(XSNR),
                  .XSRD_CYC(XSRD), .MAX_DEBT(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .refresh_ack(refresh_ack),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .refresh_req(refresh_req), .refresh_urgent(refresh_urgent),
    .block_activate(block_activate), .hold_cmds(hold_cmds),
    .cmd_precharge_all(cmd_precharge_all), .cmd_a10(cmd_a10),
    .cmd_refresh(cmd_refresh), .cke(cke), .read_block(read_block),
    .debt_count(debt_count));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      k++;
    end
    #5;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int d0;
    repeat (3) @(posedge clk);
    #5;
    // R12 reset state
    check("R12 cke", cke, 1);
    check("R12 debt", debt_count, 0);
    check("R12 hold", hold_cmds, 0);
    check("R12 req", refresh_req, 0);
    check("R12 block", block_activate, 0);
    check("R12 read_block", read_block, 0);
    rst_n = 1'b1;
    k = 0;

    // R1 R2 R3 R4: accumulation table
    for (int i = 0; i < NV; i++) begin
      step(VK[i] - k);
      check($sformatf("R1 debt k=%0d", VK[i]), debt_count, VD[i]);
      check("R2 refresh_req", refresh_req, (VD[i] != 0) ? 1 : 0);
      check("R3 urgent", refresh_urgent, VU[i]);
      check("R4 block", block_activate, VU[i]);
    end

    // R8: entry refused while a bank is open
    banks_idle = 1'b0;
    sr_enter_req = 1'b1;
    step(1);
    sr_enter_req = 1'b0;
    check("R8 ignored cke", cke, 1);
    check("R8 ignored hold", hold_cmds, 0);

    // R5: ack with open bank -> precharge all
    refresh_ack = 1'b1;
    step(1);
    refresh_ack = 1'b0;
    check("R5 precharge", cmd_precharge_all, 1);
    check("R5 a10", cmd_a10, 1);
    check("R5 hold", hold_cmds, 1);
    step(1);
    check("R5 single precharge", cmd_precharge_all, 0);
    check("R5 waits idle", cmd_refresh, 0);
    banks_idle = 1'b1;
    step(1);
    check("R5 refresh after idle", cmd_refresh, 1);
    step(1);
    check("R6 debt decrement", debt_count, 7);
    check("R4 urgent dropped", refresh_urgent, 0);
    check("R4 block held", block_activate, 1);
    step(RFC - 2);
    check("R7 hold last cycle", hold_cmds, 1);
    step(1);
    check("R7 hold released", hold_cmds, 0);

    // R6: pay the debt with banks idle
    for (int it = 0; it < 20 && debt_count != 0; it++) begin
      refresh_ack = 1'b1;
      step(1);
      refresh_ack = 1'b0;
      check("R6 refresh next cycle", cmd_refresh, 1);
      step(RFC);
    end
    check("R4 debt paid", debt_count, 0);
    check("R4 block cleared", block_activate, 0);
    check("R2 no request", refresh_req, 0);

    // R9: enter self refresh with one refresh owed
    for (int w = 0; w < 100 && !refresh_req; w++) step(1);
    check("R2 new debt", refresh_req, 1);
    sr_enter_req = 1'b1;
    step(1);
    sr_enter_req = 1'b0;
    check("R8 cke low", cke, 0);
    check("R11 read blocked in sr", read_block, 1);
    d0 = debt_count;
    step(3 * REFI + 10);
    check("R9 debt frozen", debt_count, d0);
    check("R9 still in sr", cke, 0);

    // R10 R11: exit
    sr_exit_req = 1'b1;
    step(1);
    sr_exit_req = 1'b0;
    check("R10 cke high", cke, 1);
    check("R10 debt cleared", debt_count, 0);
    step(XSNR - 1);
    check("R10 hold before refresh", hold_cmds, 1);
    check("R10 no early refresh", cmd_refresh, 0);
    step(1);
    check("R10 refresh on time", cmd_refresh, 1);
    step(XSRD - 1 - XSNR);
    check("R11 read still blocked", read_block, 1);
    step(1);
    check("R11 read released", read_block, 0);
    check("R7 traffic resumed", hold_cmds, 0);

    finish_run();
  end
endmodule